// File: doc/BRIEF.md
# Graphics Control Port Register File

This block sits behind the control port of a graphics processor. Every 32-bit control write carries a command code in its top byte and an argument in its low 24 bits. The block decodes the write and updates the 32-bit status word and the display geometry fields. It answers information queries by loading a read-back register. It also sends single-cycle pulses to the neighbouring units when a reset or a geometry change has taken effect.

A command-stream unit elsewhere updates eight drawing-environment shadow registers through a separate write port. Information queries return masked copies of those shadow registers. A bank of stored arguments, one per low command code, lets the block drop writes that only repeat the value already in place. Every output is registered, so the effect of a write is visible from the clock edge that samples it.

Top module: `gfx_ctrl_regs`

## Requirements
- R1: Asynchronous reset and an accepted command 0x00 give the same state. Status is 0x14802000. Read-back data is 0. All display fields are 0. Every shadow register i holds {0xE0+i, 24'h0}. Every stored argument is 0, except the one for command 3, which is 1.
- R2: Command 0x00 pulses full_rst_o and fifo_rst_o for one cycle. Command 0x01 pulses fifo_rst_o only. Both commands act on every write, even when the argument repeats.
- R3: A write with command 0x02..0x0F, other than 0x05, is ignored when its low 24 bits equal the last accepted argument for that command. It changes no output and raises no pulse.
- R4: Command 0x03 copies data bit 0 into status bit 23 (blanking).
- R5: Command 0x04 copies data bits [1:0] into status bits [30:29] (DMA direction). No other status bit changes.
- R6: Command 0x05 loads src_x_o from data bits [9:0] and src_y_o from data bits [18:10].
- R7: Command 0x06 loads h_start_o from bits [11:0] and h_end_o from bits [23:12]. Command 0x07 loads v_start_o from bits [9:0] and v_end_o from bits [19:10].
- R8: Command 0x08 writes data bits [5:0] to status bits [22:17] and data bit 6 to status bit 16. Other status bits are kept.
- R9: geom_chg_o pulses for one cycle after each accepted write of command 0x06, 0x07 or 0x08, and at no other time.
- R10: Commands 0x10..0x1F are queries. The selector is data bits [3:0]. Selectors 2, 3 and 4 load the read-back register with that shadow register ANDed with 0x000FFFFF. Selector 5 loads shadow register 5 ANDed with 0x003FFFFF. Selector 7 loads 2.
- R11: A query with any other selector leaves the read-back register unchanged.
- R12: env_we_i writes env_data_i into shadow register env_idx_i. An accepted command 0x00 in the same cycle wins over that write.
- R13: Commands 0x02, 0x09..0x0F and 0x20..0xFF change no output and raise no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Control write strobe |
| wr_data_i | input | 32 | Control write word: command [31:24], argument [23:0] |
| env_we_i | input | 1 | Shadow register write strobe |
| env_idx_i | input | 3 | Shadow register index |
| env_data_i | input | 32 | Shadow register write data |
| status_o | output | 32 | Status word |
| rdback_o | output | 32 | Read-back data register |
| full_rst_o | output | 1 | Full reset pulse |
| fifo_rst_o | output | 1 | Command FIFO clear and transfer abort pulse |
| geom_chg_o | output | 1 | Display geometry or mode change pulse |
| src_x_o | output | 10 | Display source X |
| src_y_o | output | 9 | Display source Y |
| h_start_o | output | 12 | Horizontal display start |
| h_end_o | output | 12 | Horizontal display end |
| v_start_o | output | 10 | Vertical display start |
| v_end_o | output | 10 | Vertical display end |

## Verification
The bench sweeps all 128 mode values, all four DMA codes and all sixteen query selectors over patterned shadow contents. A wrong bit repack or a wrong mask shows up in the compared words. For the repeat filter, the bench writes an argument of zero to a geometry command right after reset. It also writes the same argument again after another command has come in between. A filter that keys on the wrong command, or that forgets to clear on reset, raises a geometry pulse that the bench does not expect. Repeated reset and FIFO-clear writes must pulse every time, and a shadow write in the same cycle as a full reset must lose. A design that filtered these commands, or let the shadow write win, would show a missing pulse or a wrong query result.

// File: rtl/gfx_ctrl_pkg.sv
package gfx_ctrl_pkg;
  localparam int unsigned WORD_W  = 32;
  localparam int unsigned ARG_W   = 24;
  localparam int unsigned CMD_W   = 8;

  localparam logic [WORD_W-1:0] STATUS_RST = 32'h1480_2000;
  localparam logic [WORD_W-1:0] ENV_MASK_A = 32'h000F_FFFF;
  localparam logic [WORD_W-1:0] ENV_MASK_B = 32'h003F_FFFF;
  localparam logic [WORD_W-1:0] QUERY_K    = 32'd2;
  localparam logic [CMD_W-1:0]  ENV_BASE   = 8'hE0;

  localparam int unsigned BLANK_BIT = 23;
  localparam int unsigned DMA_LSB   = 29;
  localparam int unsigned MODE_LSB  = 16;

  localparam logic [CMD_W-1:0] CMD_FULL_RST = 8'h00;
  localparam logic [CMD_W-1:0] CMD_FIFO_RST = 8'h01;
  localparam logic [CMD_W-1:0] CMD_BLANK    = 8'h03;
  localparam logic [CMD_W-1:0] CMD_DMA      = 8'h04;
  localparam logic [CMD_W-1:0] CMD_SRC      = 8'h05;
  localparam logic [CMD_W-1:0] CMD_HRANGE   = 8'h06;
  localparam logic [CMD_W-1:0] CMD_VRANGE   = 8'h07;
  localparam logic [CMD_W-1:0] CMD_MODE     = 8'h08;
  localparam logic [3:0]       QUERY_GRP    = 4'h1;
endpackage

// File: rtl/gfx_ctrl_filter.sv
// Holds the last accepted argument per low command code; drops exact repeats.
module gfx_ctrl_filter import gfx_ctrl_pkg::*; #(
  parameter int unsigned NUM_CTRL = 16,
  localparam int unsigned CTRL_W  = $clog2(NUM_CTRL)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [CMD_W-1:0] cmd_i,
  input  logic [ARG_W-1:0] arg_i,
  output logic             accept_o
);
  logic [NUM_CTRL-1:0][ARG_W-1:0] stored_q;
  logic              in_range;
  logic [CTRL_W-1:0] idx;
  logic              exempt;
  logic              repeat_hit;

  assign in_range   = 32'(cmd_i) < NUM_CTRL;
  assign idx        = cmd_i[CTRL_W-1:0];
  assign exempt     = (cmd_i == CMD_FULL_RST) || (cmd_i == CMD_FIFO_RST) || (cmd_i == CMD_SRC);
  assign repeat_hit = in_range && !exempt && (stored_q[idx] == arg_i);
  assign accept_o   = wr_en_i && !repeat_hit;

  for (genvar g = 0; g < NUM_CTRL; g++) begin : g_slot
    localparam logic [ARG_W-1:0] RST_VAL = (g == 3) ? ARG_W'(1) : '0;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        stored_q[g] <= RST_VAL;
      else if (accept_o && cmd_i == CMD_FULL_RST)
        stored_q[g] <= RST_VAL;
      else if (accept_o && in_range && idx == CTRL_W'(g))
        stored_q[g] <= arg_i;
    end
  end
endmodule

// File: rtl/gfx_ctrl_env.sv
// Drawing-environment shadow registers.
module gfx_ctrl_env import gfx_ctrl_pkg::*; #(
  parameter int unsigned NUM_ENV = 8,
  localparam int unsigned ENV_W  = $clog2(NUM_ENV)
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            clear_i,
  input  logic                            we_i,
  input  logic [ENV_W-1:0]                idx_i,
  input  logic [WORD_W-1:0]               data_i,
  output logic [NUM_ENV-1:0][WORD_W-1:0]  env_o
);
  for (genvar g = 0; g < NUM_ENV; g++) begin : g_env
    localparam logic [WORD_W-1:0] RST_VAL = {CMD_W'(ENV_BASE + CMD_W'(g)), ARG_W'(0)};
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        env_o[g] <= RST_VAL;
      else if (clear_i)
        env_o[g] <= RST_VAL;
      else if (we_i && idx_i == ENV_W'(g))
        env_o[g] <= data_i;
    end
  end
endmodule

// File: rtl/gfx_ctrl_query.sv
// Information query mux: hit_o low means read-back keeps its value.
module gfx_ctrl_query import gfx_ctrl_pkg::*; #(
  parameter int unsigned NUM_ENV = 8,
  localparam int unsigned ENV_W  = $clog2(NUM_ENV)
) (
  input  logic [NUM_ENV-1:0][WORD_W-1:0] env_i,
  input  logic [3:0]                     sel_i,
  output logic                           hit_o,
  output logic [WORD_W-1:0]              val_o
);
  logic [ENV_W-1:0] eidx;
  assign eidx = ENV_W'(sel_i);

  always_comb begin
    hit_o = 1'b1;
    val_o = '0;
    unique case (sel_i)
      4'd2, 4'd3, 4'd4: val_o = env_i[eidx] & ENV_MASK_A;
      4'd5:             val_o = env_i[eidx] & ENV_MASK_B;
      4'd7:             val_o = QUERY_K;
      default:          hit_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/gfx_ctrl_regs.sv
module gfx_ctrl_regs import gfx_ctrl_pkg::*; #(
  parameter int unsigned NUM_CTRL = 16,
  parameter int unsigned NUM_ENV  = 8,
  parameter int unsigned SRCX_W   = 10,
  parameter int unsigned SRCY_W   = 9,
  parameter int unsigned HPOS_W   = 12,
  parameter int unsigned VPOS_W   = 10,
  localparam int unsigned ENV_W   = $clog2(NUM_ENV)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [31:0]       wr_data_i,
  input  logic              env_we_i,
  input  logic [ENV_W-1:0]  env_idx_i,
  input  logic [31:0]       env_data_i,
  output logic [31:0]       status_o,
  output logic [31:0]       rdback_o,
  output logic              full_rst_o,
  output logic              fifo_rst_o,
  output logic              geom_chg_o,
  output logic [SRCX_W-1:0] src_x_o,
  output logic [SRCY_W-1:0] src_y_o,
  output logic [HPOS_W-1:0] h_start_o,
  output logic [HPOS_W-1:0] h_end_o,
  output logic [VPOS_W-1:0] v_start_o,
  output logic [VPOS_W-1:0] v_end_o
);
  logic [CMD_W-1:0] cmd;
  logic [ARG_W-1:0] arg;
  logic             accept;
  logic             do_full, do_fifo, do_geom, do_query;
  logic [NUM_ENV-1:0][WORD_W-1:0] env;
  logic             q_hit;
  logic [WORD_W-1:0] q_val;
  logic [WORD_W-1:0] status_d;

  assign cmd = wr_data_i[31:24];
  assign arg = wr_data_i[23:0];

  gfx_ctrl_filter #(.NUM_CTRL(NUM_CTRL)) u_filter (
    .clk_i, .rst_ni, .wr_en_i,
    .cmd_i(cmd), .arg_i(arg), .accept_o(accept)
  );

  assign do_full  = accept && cmd == CMD_FULL_RST;
  assign do_fifo  = accept && (cmd == CMD_FULL_RST || cmd == CMD_FIFO_RST);
  assign do_geom  = accept && (cmd == CMD_HRANGE || cmd == CMD_VRANGE || cmd == CMD_MODE);
  assign do_query = accept && cmd[7:4] == QUERY_GRP;

  gfx_ctrl_env #(.NUM_ENV(NUM_ENV)) u_env (
    .clk_i, .rst_ni, .clear_i(do_full),
    .we_i(env_we_i), .idx_i(env_idx_i), .data_i(env_data_i), .env_o(env)
  );

  gfx_ctrl_query #(.NUM_ENV(NUM_ENV)) u_query (
    .env_i(env), .sel_i(arg[3:0]), .hit_o(q_hit), .val_o(q_val)
  );

  always_comb begin
    status_d = status_o;
    if (accept) begin
      unique case (cmd)
        CMD_FULL_RST: status_d = STATUS_RST;
        CMD_BLANK:    status_d[BLANK_BIT] = arg[0];
        CMD_DMA:      status_d[DMA_LSB +: 2] = arg[1:0];
        CMD_MODE:     status_d[MODE_LSB +: 7] = {arg[5:0], arg[6]};
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_o   <= STATUS_RST;
      rdback_o   <= '0;
      full_rst_o <= 1'b0;
      fifo_rst_o <= 1'b0;
      geom_chg_o <= 1'b0;
    end else begin
      status_o   <= status_d;
      full_rst_o <= do_full;
      fifo_rst_o <= do_fifo;
      geom_chg_o <= do_geom;
      if (do_full)
        rdback_o <= '0;
      else if (do_query && q_hit)
        rdback_o <= q_val;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_x_o   <= '0;
      src_y_o   <= '0;
      h_start_o <= '0;
      h_end_o   <= '0;
      v_start_o <= '0;
      v_end_o   <= '0;
    end else if (do_full) begin
      src_x_o   <= '0;
      src_y_o   <= '0;
      h_start_o <= '0;
      h_end_o   <= '0;
      v_start_o <= '0;
      v_end_o   <= '0;
    end else if (accept) begin
      if (cmd == CMD_SRC) begin
        src_x_o <= arg[0 +: SRCX_W];
        src_y_o <= arg[SRCX_W +: SRCY_W];
      end
      if (cmd == CMD_HRANGE) begin
        h_start_o <= arg[0 +: HPOS_W];
        h_end_o   <= arg[HPOS_W +: HPOS_W];
      end
      if (cmd == CMD_VRANGE) begin
        v_start_o <= arg[0 +: VPOS_W];
        v_end_o   <= arg[VPOS_W +: VPOS_W];
      end
    end
  end
endmodule

// File: rtl/gfx_ctrl_regs_chk.sv
module gfx_ctrl_regs_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        wr_en_i,
  input logic [31:0] wr_data_i,
  input logic [31:0] status_o,
  input logic [31:0] rdback_o,
  input logic        full_rst_o,
  input logic        fifo_rst_o,
  input logic        geom_chg_o
);
  a_r1_reset_status: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && wr_data_i[31:24] == 8'h00 |=> status_o == 32'h1480_2000 && rdback_o == 32'h0);

  a_r2_fifo_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && wr_data_i[31:24] == 8'h01 |=> fifo_rst_o && !full_rst_o);

  a_r2_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> !fifo_rst_o && !full_rst_o && !geom_chg_o);

  a_r4_blank_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && wr_data_i[31:24] == 8'h03 |=> status_o[23] == $past(wr_data_i[0]));

  a_r5_dma_field: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && wr_data_i[31:24] == 8'h04 |=>
      status_o[30:29] == $past(wr_data_i[1:0]) && status_o[28:0] == $past(status_o[28:0]));

  a_r8_mode_repack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && wr_data_i[31:24] == 8'h08 |=>
      status_o[22:17] == $past(wr_data_i[5:0]) && status_o[16] == $past(wr_data_i[6]));

  a_r9_geom_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(geom_chg_o) |-> $past(wr_en_i) &&
      ($past(wr_data_i[31:24]) == 8'h06 || $past(wr_data_i[31:24]) == 8'h07 ||
       $past(wr_data_i[31:24]) == 8'h08));

  a_r10_const_query: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && wr_data_i[31:28] == 4'h1 && wr_data_i[3:0] == 4'd7 |=> rdback_o == 32'd2);

  a_r11_rdback_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && wr_data_i[31:28] == 4'h1 && wr_data_i[3:0] == 4'd0 |=> $stable(rdback_o));
endmodule

bind gfx_ctrl_regs gfx_ctrl_regs_chk chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
  .status_o(status_o), .rdback_o(rdback_o), .full_rst_o(full_rst_o),
  .fifo_rst_o(fifo_rst_o), .geom_chg_o(geom_chg_o)
);

// File: tb/gfx_ctrl_regs_tb_top.sv
module gfx_ctrl_regs_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [31:0] wr_data_i = '0;
  logic        env_we_i = 1'b0;
  logic [2:0]  env_idx_i = '0;
  logic [31:0] env_data_i = '0;
  logic [31:0] status_o, rdback_o;
  logic        full_rst_o, fifo_rst_o, geom_chg_o;
  logic [9:0]  src_x_o;
  logic [8:0]  src_y_o;
  logic [11:0] h_start_o, h_end_o;
  logic [9:0]  v_start_o, v_end_o;

  always #2 clk_i = ~clk_i;

  gfx_ctrl_regs dut_i (.*);

  int n_chk = 0, n_err = 0;

  // bench model
  logic [31:0] m_st, m_rd;
  logic [23:0] m_stored [16];
  logic [31:0] m_env [8];
  logic [31:0] m_sx, m_sy, m_hs, m_he, m_vs, m_ve;
  logic        m_fr, m_ff, m_gc;

  task automatic m_reset();
    m_st = 32'h1480_2000; m_rd = '0;
    for (int i = 0; i < 16; i++) m_stored[i] = (i == 3) ? 24'd1 : 24'd0;
    for (int i = 0; i < 8; i++) m_env[i] = (32'hE0 + i) << 24;
    m_sx = 0; m_sy = 0; m_hs = 0; m_he = 0; m_vs = 0; m_ve = 0;
  endtask

  task automatic m_write(logic [31:0] d);
    logic [7:0] c;
    logic [23:0] a;
    c = d[31:24]; a = d[23:0];
    m_fr = 0; m_ff = 0; m_gc = 0;
    if (c < 16) begin
      if (c > 1 && c != 5 && m_stored[c] == a) return;
      m_stored[c] = a;
    end
    case (c)
      8'h00: begin m_reset(); m_fr = 1; m_ff = 1; end
      8'h01: m_ff = 1;
      8'h03: m_st[23] = a[0];
      8'h04: m_st[30:29] = a[1:0];
      8'h05: begin m_sx = a & 24'h3FF; m_sy = (a >> 10) & 24'h1FF; end
      8'h06: begin m_hs = a & 24'hFFF; m_he = (a >> 12) & 24'hFFF; m_gc = 1; end
      8'h07: begin m_vs = a & 24'h3FF; m_ve = (a >> 10) & 24'h3FF; m_gc = 1; end
      8'h08: begin
        m_st = (m_st & ~32'h007F_0000) | ((d & 32'h3F) << 17) | ((d & 32'h40) << 10);
        m_gc = 1;
      end
      default: if (c[7:4] == 4'h1) begin
        case (a[3:0])
          4'd2, 4'd3, 4'd4: m_rd = m_env[a[2:0]] & 32'h000F_FFFF;
          4'd5: m_rd = m_env[5] & 32'h003F_FFFF;
          4'd7: m_rd = 32'd2;
          default: ;
        endcase
      end
    endcase
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    chk({tag, " status"}, status_o, m_st);
    chk({tag, " rdback"}, rdback_o, m_rd);
    chk({tag, " pulses"}, {29'd0, full_rst_o, fifo_rst_o, geom_chg_o}, {29'd0, m_fr, m_ff, m_gc});
    chk({tag, " src"}, {22'd0, src_y_o, src_x_o}, {m_sy[21:0], m_sx[9:0]});
    chk({tag, " hrange"}, {8'd0, h_end_o, h_start_o}, {8'd0, m_he[11:0], m_hs[11:0]});
    chk({tag, " vrange"}, {12'd0, v_end_o, v_start_o}, {12'd0, m_ve[9:0], m_vs[9:0]});
  endtask

  // drive at negedge, check at following negedge (one edge later)
  task automatic wr(logic [31:0] d, string tag);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
    m_write(d);
    check_all(tag);
  endtask

  task automatic env_wr(int idx, logic [31:0] d);
    @(negedge clk_i);
    env_we_i = 1'b1; env_idx_i = 3'(idx); env_data_i = d;
    @(negedge clk_i);
    env_we_i = 1'b0;
    m_env[idx] = d;
  endtask

  task automatic query_sweep(string tag);
    for (int s = 0; s < 16; s++) wr({8'h10 | 8'(s), 20'h0, 4'(s)}, tag);
  endtask

  initial begin
    #(4 * 200000);
    n_err++;
    $display("FAIL watchdog expired act=running exp=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    m_reset(); m_fr = 0; m_ff = 0; m_gc = 0;
    repeat (3) @(negedge clk_i);
    check_all("R1 async reset");
    rst_ni = 1'b1;
    @(negedge clk_i);
    check_all("R1 after release");

    // R1 R12 reset shadow values seen through queries
    query_sweep("R1 R12 reset shadow query");

    // R3 zero argument right after reset is a repeat
    wr(32'h0600_0000, "R3 repeat after reset");
    wr(32'h0700_0000, "R3 repeat after reset v");
    wr(32'h0800_0000, "R3 repeat after reset mode");

    // R12 R10 R11 patterned shadow contents, full selector sweep
    for (int i = 0; i < 8; i++) env_wr(i, 32'hA5C3_9E17 ^ (32'h0135_7BDF * (i + 1)));
    query_sweep("R10 R11 R12 query sweep");
    wr(32'h1200_0007, "R10 const");
    wr(32'h1F00_000A, "R11 hold");
    wr(32'h1000_0000, "R11 hold zero");

    // R4 blanking
    wr(32'h0300_0000, "R4 blank off");
    wr(32'h03FF_FFFE, "R4 blank off repeat data");
    wr(32'h0300_0001, "R4 blank on");

    // R5 DMA sweep
    for (int k = 0; k < 4; k++) wr({8'h04, 20'hABCDE, 2'b0, 2'(k)}, "R5 dma");
    wr(32'h0400_0000, "R5 dma clear");

    // R8 R9 mode sweep
    for (int k = 1; k < 128; k++) wr({8'h08, 16'h0, 1'b0, 7'(k)}, "R8 R9 mode");
    wr(32'h0800_007F, "R3 R9 mode repeat");

    // R6 R7 R9 geometry
    wr(32'h05FF_FFFF, "R6 src all ones");
    wr(32'h0501_5A5A, "R6 src pattern");
    wr(32'h0501_5A5A, "R6 src repeat");
    wr(32'h06AB_C123, "R7 R9 hrange");
    wr(32'h07F5_5AA5, "R7 R9 vrange");
    wr(32'h06AB_C123, "R3 R9 hrange repeat");
    wr(32'h07F5_5AA5, "R3 R9 vrange repeat");
    wr(32'h06AB_C124, "R7 R9 hrange change");
    wr(32'h0600_0000, "R7 R9 hrange zero");

    // R13 inert commands
    wr(32'h0212_3456, "R13 cmd02");
    for (int c = 9; c < 16; c++) wr({8'(c), 24'h5A_A5C3}, "R13 low unused");
    wr(32'h2000_0007, "R13 cmd20");
    wr(32'hE100_0002, "R13 cmdE1");
    wr(32'hFF00_0004, "R13 cmdFF");

    // R2 FIFO clear repeated
    wr(32'h0100_0000, "R2 fifo clear");
    wr(32'h0100_0000, "R2 fifo clear repeat");

    // R2 R1 full reset, repeated
    wr(32'h0012_3456, "R1 R2 full reset");
    wr(32'h0012_3456, "R1 R2 full reset repeat");
    query_sweep("R1 shadow after full reset");

    // R12 shadow write loses against full reset in the same cycle
    env_wr(2, 32'h0001_2345);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_data_i = 32'h0000_0000;
    env_we_i = 1'b1; env_idx_i = 3'd4; env_data_i = 32'h000F_FFFF;
    @(negedge clk_i);
    wr_en_i = 1'b0; env_we_i = 1'b0;
    m_write(32'h0000_0000);
    check_all("R12 R1 reset vs env write");
    wr(32'h1000_0004, "R12 reset priority query4");
    wr(32'h1000_0002, "R12 reset priority query2");

    // R1 async reset mid-run
    wr(32'h0300_0000, "R4 pre async");
    wr(32'h0400_0002, "R5 pre async");
    @(negedge clk_i);
    rst_ni = 1'b0;
    @(negedge clk_i);
    m_reset(); m_fr = 0; m_ff = 0; m_gc = 0;
    check_all("R1 async mid-run");
    rst_ni = 1'b1;
    wr(32'h0300_0001, "R1 R3 reg3 reset to one");

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule